// File: doc/BRIEF.md
# Watchdog Timer with Selectable Time-Out Response

This block is a down-counting watchdog that runs from a slow tick enable derived from a dedicated low-frequency oscillator. It uses the system clock throughout. Software keeps it quiet by pulsing a refresh strobe before the count runs out. If software fails to do so, the watchdog either asks for a chip reset or raises a system exception and then keeps running. A configuration input chooses which of the two happens. The reload value comes from outside, from the register or option bit that holds it, and is 0400h after a chip reset. A reload of 0000h means the longest period, 65,536 ticks.

Three states form the core: `WD_IDLE`, `WD_RUN` and `WD_HOLD`. A fourth, `WD_FIRED`, is reached only after a reset request.

- `WD_IDLE` is the state until the first enable after reset. The transition `WD_IDLE -> WD_RUN` on enable loads the counter.
- `WD_RUN` counts down on tick cycles. Refresh and debug both reload the counter.
- On a time-out in exception mode, the block stays in `WD_RUN` and reloads itself.
- On a time-out in reset mode, it takes the transition `WD_RUN -> WD_FIRED` and stays in `WD_FIRED` until reset.
- Dropping enable takes the transition `WD_RUN -> WD_HOLD`, which freezes the count.
- Raising enable again takes the transition `WD_HOLD -> WD_RUN`, which resumes the count without a reload.

A time-out in exception mode while the stop-mode flag is high also requests a wake-up from stop mode, and it sets a stop status bit next to the watchdog status bit.

Top module: `wdog_timer`

## Requirements
- R1: On the first enable after reset the counter loads the reload value N. With `tick_en` held high, the time-out request appears at the output N+1 clock cycles after enable is first sampled: one cycle for the load, then N ticks.
- R2: A reload value of 0000h gives a period of 65,536 ticks.
- R3: With `resp_sel_rst`=1 a time-out raises `rst_req` for exactly one cycle. No further request follows until reset.
- R4: With `resp_sel_rst`=0 a time-out raises `exc_req` for one cycle. The counter reloads itself, so the next `exc_req` follows N cycles later with ticks every cycle. `rst_req` and `exc_req` are never high together.
- R5: `kick` reloads the counter, and the time-out then follows N+1 cycles after the kick edge. A kick on the very cycle of a time-out wins, and no request is raised.
- R6: While `dbg_mode` is high the counter is reloaded on every cycle and no request is raised. After `dbg_mode` falls, the time-out follows N cycles later.
- R7: A time-out in exception mode while `stop_mode` is high pulses `stop_wake_req` together with `exc_req`. In reset mode `stop_wake_req` stays low.
- R8: `wd_flag` is set by every time-out. `stop_flag` is set by a stop-mode exception time-out. Both stay set until `status_clr`, which clears both.
- R9: While `wd_enable` is low the count is frozen and no request is raised. Re-enabling resumes from the frozen count without a reload.
- R10: The counter advances only on cycles with `tick_en` high. Without ticks no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow-oscillator tick enable, one clock wide per tick |
| wd_enable | input | 1 | Watchdog enable |
| kick | input | 1 | Refresh strobe |
| dbg_mode | input | 1 | Debug mode active; forces continuous refresh |
| stop_mode | input | 1 | Core is in stop mode |
| resp_sel_rst | input | 1 | 1: reset on time-out, 0: system exception |
| reload_val | input | 16 | Reload value (0000h means 65,536) |
| status_clr | input | 1 | Clears both status bits |
| rst_req | output | 1 | Reset request pulse |
| exc_req | output | 1 | System-exception request pulse |
| stop_wake_req | output | 1 | Stop-mode recovery request pulse |
| wd_flag | output | 1 | Sticky watchdog time-out status |
| stop_flag | output | 1 | Sticky stop-mode time-out status |

## Verification
All request and status outputs are registered once after the edge that decides the time-out. The first request therefore appears N+1 cycles after an enable or kick edge, and N cycles after an automatic reload or after debug mode ends. A resumed count after re-enable also shows the extra cycle. The bench drives inputs on the falling edge, counts rising edges from the stimulus and samples on the falling edge. It compares the counted edges against those figures, and it checks that the kind of request and the status bits match on that same sample. Quiet periods are checked by watching for a bounded number of cycles that nothing is requested.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_RUN   = 2'd1,
        WD_HOLD  = 2'd2,
        WD_FIRED = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_dec,
    input  logic [CNT_W-1:0] reload,
    output logic             cnt_one
);
    localparam int LW = CNT_W + 1;

    logic [LW-1:0] cnt_q;
    logic [LW-1:0] load_val;

    // a zero reload stands for the full 2**CNT_W period
    always_comb begin
        if (reload == '0) load_val = {1'b1, {CNT_W{1'b0}}};
        else              load_val = {1'b0, reload};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (do_load) cnt_q <= load_val;
        else if (do_dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_one = (cnt_q == LW'(1));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic kick,
    input  logic dbg,
    input  logic tick,
    input  logic resp_rst,
    input  logic cnt_one,
    output logic do_load,
    output logic do_dec,
    output logic to_hit
);
    wd_state_e st_q, st_d;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_IDLE:  if (enable) st_d = WD_RUN;
            WD_RUN: begin
                if (!enable)
                    st_d = WD_HOLD;
                else if (!kick && !dbg && tick && cnt_one && resp_rst)
                    st_d = WD_FIRED;
            end
            WD_HOLD:  if (enable) st_d = WD_RUN;
            WD_FIRED: st_d = WD_FIRED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WD_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        do_load = 1'b0;
        do_dec  = 1'b0;
        to_hit  = 1'b0;
        unique case (st_q)
            WD_IDLE:  do_load = enable;
            WD_RUN: begin
                if (enable) begin
                    if (kick || dbg) begin
                        do_load = 1'b1;
                    end else if (tick) begin
                        if (cnt_one) begin
                            to_hit  = 1'b1;
                            do_load = !resp_rst;
                        end else begin
                            do_dec = 1'b1;
                        end
                    end
                end
            end
            WD_HOLD:  ;
            WD_FIRED: ;
        endcase
    end
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic to_hit,
    input  logic resp_rst,
    input  logic stop_mode,
    input  logic status_clr,
    output logic rst_req,
    output logic exc_req,
    output logic stop_wake_req,
    output logic wd_flag,
    output logic stop_flag
);
    logic exc_hit, wake_hit;

    assign exc_hit  = to_hit && !resp_rst;
    assign wake_hit = exc_hit && stop_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req       <= 1'b0;
            exc_req       <= 1'b0;
            stop_wake_req <= 1'b0;
        end else begin
            rst_req       <= to_hit && resp_rst;
            exc_req       <= exc_hit;
            stop_wake_req <= wake_hit;
        end
    end

    // sticky status, a new event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_flag   <= 1'b0;
            stop_flag <= 1'b0;
        end else begin
            if (to_hit)          wd_flag <= 1'b1;
            else if (status_clr) wd_flag <= 1'b0;
            if (wake_hit)        stop_flag <= 1'b1;
            else if (status_clr) stop_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wd_enable,
    input  logic             kick,
    input  logic             dbg_mode,
    input  logic             stop_mode,
    input  logic             resp_sel_rst,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             status_clr,
    output logic             rst_req,
    output logic             exc_req,
    output logic             stop_wake_req,
    output logic             wd_flag,
    output logic             stop_flag
);
    logic do_load, do_dec, to_hit, cnt_one;

    wdog_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (wd_enable),
        .kick     (kick),
        .dbg      (dbg_mode),
        .tick     (tick_en),
        .resp_rst (resp_sel_rst),
        .cnt_one  (cnt_one),
        .do_load  (do_load),
        .do_dec   (do_dec),
        .to_hit   (to_hit)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_load (do_load),
        .do_dec  (do_dec),
        .reload  (reload_val),
        .cnt_one (cnt_one)
    );

    wdog_resp u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .to_hit        (to_hit),
        .resp_rst      (resp_sel_rst),
        .stop_mode     (stop_mode),
        .status_clr    (status_clr),
        .rst_req       (rst_req),
        .exc_req       (exc_req),
        .stop_wake_req (stop_wake_req),
        .wd_flag       (wd_flag),
        .stop_flag     (stop_flag)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic wd_enable,
    input logic kick,
    input logic dbg_mode,
    input logic status_clr,
    input logic rst_req,
    input logic exc_req,
    input logic stop_wake_req,
    input logic wd_flag,
    input logic stop_flag
);
    a_r3_single_rst: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    a_r4_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !exc_req);
    a_r5_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !(exc_req || rst_req));
    a_r6_dbg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |=> !(exc_req || rst_req));
    a_r7_wake_with_exc: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wake_req |-> exc_req);
    a_r8_wd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !status_clr) |=> wd_flag);
    a_r8_stop_needs_wd: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |-> wd_flag);
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !(exc_req || rst_req));
    a_r10_no_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> !(exc_req || rst_req));
endmodule

bind wdog_timer wdog_timer_chk chk_i (.*);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {reload[17:2], resp_sel_rst[1], stop_mode[0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {16'h0400, 1'b0, 1'b0},
        {16'h0005, 1'b1, 1'b1},
        {16'h0003, 1'b0, 1'b1},
        {16'h0001, 1'b1, 1'b0},
        {16'h0002, 1'b0, 1'b0},
        {16'h0000, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, wd_enable = 1'b0, kick = 1'b0, dbg_mode = 1'b0;
    logic stop_mode = 1'b0, resp_sel_rst = 1'b0, status_clr = 1'b0;
    logic [15:0] reload_val = 16'h0400;
    logic rst_req, exc_req, stop_wake_req, wd_flag, stop_flag;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wd_enable = 1'b0; kick = 1'b0; dbg_mode = 1'b0;
        tick_en = 1'b1; status_clr = 1'b0; stop_mode = 1'b0; resp_sel_rst = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // edges until any request is seen on a falling-edge sample; 0 if none
    task automatic wait_req(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_req || exc_req) begin
                n = i;
                return;
            end
        end
    endtask

    function automatic int period(input logic [15:0] r);
        return (r == 16'h0) ? 65536 : int'(r);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, np;
        do_reset();
        chk({rst_req, exc_req, stop_wake_req, wd_flag, stop_flag} == 5'b0,
            "R8 reset state", int'({rst_req, exc_req, stop_wake_req, wd_flag, stop_flag}), 0);

        // table walk: R1 R2 R3 R4 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            reload_val   = VEC[v][17:2];
            resp_sel_rst = VEC[v][1];
            stop_mode    = VEC[v][0];
            np = period(reload_val);
            wd_enable = 1'b1;
            wait_req(np + 10, n);
            chk(n == np + 1, (reload_val == 0) ? "R2 full period" : "R1 first time-out", n, np + 1);
            chk(rst_req == VEC[v][1], "R3 reset request kind", int'(rst_req), int'(VEC[v][1]));
            chk(exc_req == !VEC[v][1], "R4 exception kind", int'(exc_req), int'(!VEC[v][1]));
            chk(stop_wake_req == (!VEC[v][1] && VEC[v][0]), "R7 stop wake",
                int'(stop_wake_req), int'(!VEC[v][1] && VEC[v][0]));
            chk(wd_flag == 1'b1, "R8 watchdog flag", int'(wd_flag), 1);
            chk(stop_flag == (!VEC[v][1] && VEC[v][0]), "R8 stop flag",
                int'(stop_flag), int'(!VEC[v][1] && VEC[v][0]));
            if (VEC[v][1]) begin
                wait_req(3 * np + 10, n);
                chk(n == 0, "R3 no second request", n, 0);
            end else if (np <= 1024) begin
                wait_req(np + 10, n);
                chk(n == np, "R4 auto reload period", n, np);
            end
        end

        // R8 clear
        chk(wd_flag == 1'b1, "R8 flag still set", int'(wd_flag), 1);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        wd_enable = 1'b0;
        chk(wd_flag == 1'b0 && stop_flag == 1'b0, "R8 clear", int'({wd_flag, stop_flag}), 0);

        // R5 kick mid-count
        do_reset();
        reload_val = 16'd10; wd_enable = 1'b1;
        repeat (5) @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        wait_req(40, n);
        chk(n + 1 == 11, "R5 kick reload", n + 1, 11);

        // R5 kick on the time-out cycle
        do_reset();
        reload_val = 16'd4; wd_enable = 1'b1;
        repeat (4) @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        chk(!(rst_req || exc_req), "R5 kick beats time-out", int'(exc_req), 0);
        wait_req(40, n);
        chk(n + 1 == 5, "R5 after colliding kick", n + 1, 5);

        // R6 debug mode
        do_reset();
        reload_val = 16'd4; dbg_mode = 1'b1; wd_enable = 1'b1;
        wait_req(50, n);
        chk(n == 0, "R6 debug quiet", n, 0);
        dbg_mode = 1'b0;
        wait_req(40, n);
        chk(n == 4, "R6 after debug", n, 4);

        // R10 no ticks
        do_reset();
        reload_val = 16'd3; tick_en = 1'b0; wd_enable = 1'b1;
        wait_req(20, n);
        chk(n == 0, "R10 no ticks quiet", n, 0);
        tick_en = 1'b1;
        wait_req(40, n);
        chk(n == 3, "R10 ticks resume", n, 3);

        // R9 disable freezes, re-enable resumes
        do_reset();
        reload_val = 16'd6; wd_enable = 1'b1;
        repeat (3) @(negedge clk);
        wd_enable = 1'b0;
        wait_req(20, n);
        chk(n == 0, "R9 disabled quiet", n, 0);
        wd_enable = 1'b1;
        wait_req(40, n);
        chk(n == 5, "R9 resume without reload", n, 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule